// File: doc/BRIEF.md
# Character LCD Init and Row Writer

This block drives a 20-column by 4-line character display over an 8-bit parallel write bus with an enable strobe, a register-select line and a read/write line. After reset it issues a fixed five-command setup sequence. It then repaints the screen without end, one line at a time. For each line it sends that line's start address as a command, then twenty character codes.

Each line shows a small label and one 8-bit number taken from the `field_vals` input. Before a line is painted, the number for that line is turned into three decimal digits. A sequential shift-and-add-3 converter does this, and the digits are kept in a small buffer. Characters are sent as ASCII. All timing counts in ticks of an internal divider fed by the system clock. The read/write line never leaves write.

Top module: `lcd_row_writer`

## Requirements
- R1: While reset is held, `lcd_en` and `lcd_rw` are 0.
- R2: The first five bytes after reset are the commands 38h, 0Eh, 01h, 1Ch, 02h, in that order, each with `lcd_rs` = 0. No byte with `lcd_rs` = 1 is sent before all five are done.
- R3: The time from an enable falling edge to the next enable rising edge is at least LONG_WAIT×CLK_DIV clocks after the commands 01h and 02h. After every other byte it is at least SHORT_WAIT×CLK_DIV clocks.
- R4: Every enable pulse is high for exactly EN_TICKS×CLK_DIV clocks. `lcd_data` and `lcd_rs` hold their values from at least one clock before the rising edge until the falling edge.
- R5: After setup, the lines are painted in the order 0, 1, 2, 3, 0, and so on. Each line opens with its start-address command (`lcd_rs` = 0): 80h, C0h, 94h or D4h for lines 0 to 3.
- R6: Each address command is followed by exactly COLS (20) character bytes, each with `lcd_rs` = 1.
- R7: In line r, column 0 holds 41h+r ('A'..'D') and column 1 holds 3Ah (':'). Columns 2, 3 and 4 hold the hundreds, tens and units digits of `field_vals[8r+7:8r]`, each written as 30h plus the digit. Columns 5 to 19 hold 20h (space).
- R8: `field_vals` for a line is sampled when that line's conversion starts, so a value that changes between refresh passes appears in the next pass.
- R9: `lcd_rw` is 0 at every enable falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_vals | input | 32 | Four 8-bit numbers; byte r is shown on line r |
| lcd_en | output | 1 | Enable strobe; the display latches data on its falling edge |
| lcd_rs | output | 1 | 0 = command or address, 1 = character |
| lcd_rw | output | 1 | Read/write select, always 0 (write) |
| lcd_data | output | 8 | Command or character byte |

## Verification
The hardest cases to reach are the timing rules that apply only to the clear and return-home commands. Each of these occurs once per reset, so the long wait is measured by a bus monitor that counts idle clocks before every enable rise and compares the count with a model of the wait for the previous byte. The digit path is driven with directed field values 0, 9, 10, 99, 100, 200 and 255 in the first two passes and with seeded random values after that. Values change only between refresh passes, so each pass checks that the new numbers are picked up.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int ROWS     = 4;
  localparam int INIT_LEN = 5;
  localparam int VAL_W    = 8;
  localparam int DIGITS   = 3;
  localparam int SH_W     = 4 * DIGITS + VAL_W;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} bus_phase_t;
  typedef enum logic [1:0] {ST_INIT, ST_CONV, ST_ADDR, ST_CHAR} seq_state_t;

  // setup command for step i of the power-on sequence
  function automatic logic [7:0] init_cmd(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h38;
      3'd1:    return 8'h0E;
      3'd2:    return 8'h01;
      3'd3:    return 8'h1C;
      default: return 8'h02;
    endcase
  endfunction

  // set-address command opening each line (lines are not contiguous)
  function automatic logic [7:0] row_base(input logic [1:0] r);
    case (r)
      2'd0:    return 8'h80;
      2'd1:    return 8'hC0;
      2'd2:    return 8'h94;
      default: return 8'hD4;
    endcase
  endfunction

  // clear and return-home need the long settling time
  function automatic logic slow_cmd(input logic [7:0] b);
    return (b == 8'h01) || (b == 8'h02);
  endfunction

  // one shift-and-add-3 step over {bcd digits, binary remainder}
  function automatic logic [SH_W-1:0] dd_step(input logic [SH_W-1:0] s);
    logic [SH_W-1:0] t;
    t = s;
    for (int k = 0; k < DIGITS; k++) begin
      if (t[VAL_W+4*k +: 4] >= 4'd5) t[VAL_W+4*k +: 4] = t[VAL_W+4*k +: 4] + 4'd3;
    end
    return t << 1;
  endfunction

  // character code for a given line and column
  function automatic logic [7:0] cell_char(input logic [1:0] row, input logic [7:0] col,
                                           input logic [4*DIGITS-1:0] bcd);
    case (col)
      8'd0:    return 8'h41 + {6'd0, row};
      8'd1:    return 8'h3A;
      8'd2:    return {4'h3, bcd[11:8]};
      8'd3:    return {4'h3, bcd[7:4]};
      8'd4:    return {4'h3, bcd[3:0]};
      default: return 8'h20;
    endcase
  endfunction
endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_bus_drv.sv
module lcd_bus_drv
  import lcd_pkg::*;
#(
  parameter int EN_TICKS   = 1,
  parameter int SHORT_WAIT = 50,
  parameter int LONG_WAIT  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       go_rs,
  input  logic [7:0] go_data,
  output logic       ready,
  output logic       done,
  output logic       lcd_en,
  output logic       lcd_rs,
  output logic [7:0] lcd_data
);
  localparam int MAXT = (LONG_WAIT > EN_TICKS) ? LONG_WAIT : EN_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  bus_phase_t    phase;
  logic [CW-1:0] cnt;
  logic          long_q;

  assign ready = (phase == PH_IDLE) && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      long_q   <= 1'b0;
      done     <= 1'b0;
      lcd_en   <= 1'b0;
      lcd_rs   <= 1'b0;
      lcd_data <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (go) begin
          lcd_rs   <= go_rs;
          lcd_data <= go_data;
          long_q   <= !go_rs && slow_cmd(go_data);
          cnt      <= CW'(1);
          phase    <= PH_SETUP;
        end
        PH_SETUP: if (tick) begin
          if (cnt == '0) begin
            lcd_en <= 1'b1;
            cnt    <= CW'(EN_TICKS - 1);
            phase  <= PH_PULSE;
          end else cnt <= cnt - 1'b1;
        end
        PH_PULSE: if (tick) begin
          if (cnt == '0) begin
            lcd_en <= 1'b0;
            cnt    <= long_q ? CW'(LONG_WAIT - 1) : CW'(SHORT_WAIT - 1);
            phase  <= PH_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        default: if (tick) begin
          if (cnt == '0) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R4: bus lines frozen while the strobe is high
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));
  // R4: a new byte is only accepted while the bus is idle
  a_r4_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (phase == PH_IDLE));
endmodule

// File: rtl/lcd_bcd8.sv
module lcd_bcd8
  import lcd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VAL_W-1:0]      value,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd
);
  localparam int STW = $clog2(VAL_W + 1);
  logic [SH_W-1:0] sh;
  logic [STW-1:0]  step;

  assign bcd = sh[SH_W-1:VAL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh   <= {{(4*DIGITS){1'b0}}, value};
        step <= STW'(VAL_W);
      end else if (step != '0) begin
        sh   <= dd_step(sh);
        step <= step - 1'b1;
        if (step == STW'(1)) done <= 1'b1;
      end
    end
  end

  // R7: every finished conversion yields valid decimal digits, at most 255
  a_r7_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcd[11:8] <= 4'd2 && bcd[7:4] <= 4'd9 && bcd[3:0] <= 4'd9));
endmodule

// File: rtl/lcd_row_writer.sv
module lcd_row_writer
  import lcd_pkg::*;
#(
  parameter int CLK_DIV    = 100,
  parameter int EN_TICKS   = 1,
  parameter int SHORT_WAIT = 50,
  parameter int LONG_WAIT  = 2000,
  parameter int COLS       = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ROWS*VAL_W-1:0]   field_vals,
  output logic                    lcd_en,
  output logic                    lcd_rs,
  output logic                    lcd_rw,
  output logic [7:0]              lcd_data
);
  localparam int CCW = $clog2(COLS);

  seq_state_t          st;
  logic [2:0]          idx;
  logic [1:0]          row;
  logic [CCW-1:0]      col;
  logic                conv_req;
  logic [4*DIGITS-1:0] digits;

  logic                tick, tx_go, tx_rs, tx_ready, tx_done, want_send;
  logic [7:0]          tx_data;
  logic                conv_done;
  logic [4*DIGITS-1:0] conv_bcd;
  logic                init_done;

  assign lcd_rw    = 1'b0;
  assign init_done = (st != ST_INIT);
  assign want_send = (st != ST_CONV);
  assign tx_go     = want_send && tx_ready;
  assign tx_rs     = (st == ST_CHAR);

  always_comb begin
    case (st)
      ST_INIT: tx_data = init_cmd(idx);
      ST_ADDR: tx_data = row_base(row);
      ST_CHAR: tx_data = cell_char(row, 8'(col), digits);
      default: tx_data = 8'h00;
    endcase
  end

  lcd_tick_gen #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  lcd_bus_drv #(.EN_TICKS(EN_TICKS), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_bus (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(tx_go), .go_rs(tx_rs), .go_data(tx_data),
    .ready(tx_ready), .done(tx_done), .lcd_en(lcd_en), .lcd_rs(lcd_rs), .lcd_data(lcd_data));

  lcd_bcd8 u_bcd (
    .clk(clk), .rst_n(rst_n), .start(conv_req), .value(field_vals[VAL_W*row +: VAL_W]),
    .done(conv_done), .bcd(conv_bcd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_INIT;
      idx      <= '0;
      row      <= '0;
      col      <= '0;
      conv_req <= 1'b0;
      digits   <= '0;
    end else begin
      case (st)
        ST_INIT: if (tx_done) begin
          if (idx == 3'(INIT_LEN - 1)) begin
            st       <= ST_CONV;
            row      <= '0;
            conv_req <= 1'b1;
          end else idx <= idx + 1'b1;
        end
        ST_CONV: begin
          conv_req <= 1'b0;
          if (conv_done) begin
            digits <= conv_bcd;
            st     <= ST_ADDR;
          end
        end
        ST_ADDR: if (tx_done) begin
          col <= '0;
          st  <= ST_CHAR;
        end
        default: if (tx_done) begin
          if (col == CCW'(COLS - 1)) begin
            row      <= row + 1'b1;
            st       <= ST_CONV;
            conv_req <= 1'b1;
          end else col <= col + 1'b1;
        end
      endcase
    end
  end

  // R2: no character byte reaches the bus before setup completes
  a_r2_rs_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rs |-> init_done);
  // R6: column index stays within one line
  a_r6_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    col <= CCW'(COLS - 1));
endmodule

// File: tb/sim_lcd_row_writer.sv
module sim_lcd_row_writer;
  localparam int DIV = 3, ENT = 2, SW = 3, LW = 10, COLS = 20;
  localparam int BPF = 4 * (COLS + 1);
  localparam int NFRAMES = 6;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fv;
  logic en, rs, rw;
  logic [7:0] data;

  always #5 clk = ~clk;

  lcd_row_writer #(.CLK_DIV(DIV), .EN_TICKS(ENT), .SHORT_WAIT(SW), .LONG_WAIT(LW), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .field_vals(fv), .lcd_en(en), .lcd_rs(rs), .lcd_rw(rw), .lcd_data(data));

  int checks = 0, fails = 0, frames = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected {rs, byte} of the n-th byte after reset
  function automatic logic [8:0] exp_byte(input int n, input logic [31:0] f);
    int k, r, c;
    logic [7:0] v;
    if (n < 5) begin
      case (n)
        0: return {1'b0, 8'h38};
        1: return {1'b0, 8'h0E};
        2: return {1'b0, 8'h01};
        3: return {1'b0, 8'h1C};
        default: return {1'b0, 8'h02};
      endcase
    end
    k = (n - 5) % BPF;
    r = k / (COLS + 1);
    c = k % (COLS + 1);
    if (c == 0) begin
      case (r)
        0: return {1'b0, 8'h80};
        1: return {1'b0, 8'hC0};
        2: return {1'b0, 8'h94};
        default: return {1'b0, 8'hD4};
      endcase
    end
    v = f[8*r +: 8];
    case (c - 1)
      0: return {1'b1, 8'(8'h41 + r)};
      1: return {1'b1, 8'h3A};
      2: return {1'b1, 8'(8'h30 + v / 100)};
      3: return {1'b1, 8'(8'h30 + (v / 10) % 10)};
      4: return {1'b1, 8'(8'h30 + v % 10)};
      default: return {1'b1, 8'h20};
    endcase
  endfunction

  function automatic int wait_of(input logic [8:0] e);
    return (!e[8] && (e[7:0] == 8'h01 || e[7:0] == 8'h02)) ? LW : SW;
  endfunction

  // bus monitor, sampled on the falling clock edge
  logic prev_en = 1'b0, unstable = 1'b0, have_prev = 1'b0;
  logic [7:0] prev_data = '0, rise_data = '0;
  logic prev_rs = 1'b0, rise_rs = 1'b0;
  int hi = 0, lo = 0, nbyte = 0, prev_wait = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (en && !prev_en) begin
        if (have_prev)
          check(lo >= prev_wait * DIV, (prev_wait == LW) ? "R3 long gap" : "R3 short gap", lo, prev_wait * DIV);
        check(data == prev_data && rs == prev_rs, "R4 setup", data, prev_data);
        rise_data = data; rise_rs = rs; unstable = 1'b0; hi = 1;
      end else if (en) begin
        hi++;
        if (data != rise_data || rs != rise_rs) unstable = 1'b1;
      end else if (prev_en) begin
        logic [8:0] e;
        int k, c;
        string req;
        e = exp_byte(nbyte, fv);
        k = (nbyte - 5) % BPF;
        c = k % (COLS + 1);
        check(hi == ENT * DIV, "R4 width", hi, ENT * DIV);
        check(!unstable, "R4 hold", rise_data, data);
        check(rw == 1'b0, "R9 rw", rw, 0);
        if (nbyte < 5) req = "R2";
        else if (c == 0) req = "R5";
        else if (c >= 3 && c <= 5) req = (frames > 0) ? "R8" : "R7";
        else req = "R7";
        check(rs == e[8], (nbyte < 5 || c == 0) ? req : "R6", rs, e[8]);
        check(rise_data == e[7:0], req, rise_data, e[7:0]);
        prev_wait = wait_of(e);
        have_prev = 1'b1;
        if (nbyte >= 5 && k == BPF - 1) frames++;
        nbyte++;
        lo = 1;
      end else lo++;
    end
    prev_en = en;
    prev_data = data;
    prev_rs = rs;
  end

  initial begin
    int cyc, last;
    void'($urandom(32'd4099));
    fv = {8'd9, 8'd100, 8'd255, 8'd0};
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(en == 1'b0, "R1 en in reset", en, 0);
    check(rw == 1'b0, "R1 rw in reset", rw, 0);
    rst_n = 1'b1;
    cyc = 0; last = 0;
    while (frames < NFRAMES && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (frames != last) begin
        last = frames;
        if (frames == 1) fv = {8'd200, 8'd1, 8'd10, 8'd99};
        else fv = $urandom;
      end
    end
    if (cyc >= LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d frames expected %0d", frames, NFRAMES);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule